// File: doc/BRIEF.md
# ADC Channel/Gain Queue Sequencer

This block holds a short list of analog front-end settings and presents one setting at a time to a scanning converter. Software first clears the list, then appends 16-bit entries. Each entry carries a channel number, a gain code, a unipolar flag, a single-ended flag and two end markers. A priming strobe copies the first entry into an output holding register. Each conversion strobe from the pacer then moves the holding register on to the next entry.

An entry with the end-of-scan marker raises a one-cycle pulse for the pacer when a conversion consumes it, so the pacer can insert its inter-scan delay. An entry with the end-of-sequence marker sends the sequencer back to entry 0. In a second, internal stepping mode, the channel counts upward from the channel of entry 0 to a given high channel, and the other settings come from entry 0.

Top module: `adc_chan_queue_seq`

## Requirements
- R1: Entry layout: bits 7:0 are the channel, bits 9:8 the gain code, bit 12 set means single-ended (clear means differential), bit 13 the unipolar flag, bit 14 end-of-sequence and bit 15 end-of-scan. `hold_o` shows the holding register, and `chan_o`, `gain_o`, `single_o` and `unip_o` decode it.
- R2: `clr_i` empties the list, resets the read position, clears `valid_o`, `hold_o` and `overflow_o`, and ignores any push, prime or conversion in the same cycle. The clear takes effect at the next clock edge.
- R3: A push with fewer than DEPTH (default 16) entries stored appends `push_data_i` after the last stored entry.
- R4: A push while DEPTH entries are stored is dropped. It sets `overflow_o`, which then stays set until a clear.
- R5: A prime with at least one entry stored loads entry 0 into the holding register and sets `valid_o` at the next edge. A prime on an empty list has no effect. A prime takes precedence over a conversion strobe in the same cycle.
- R6: A conversion strobe while `valid_o` is set loads the entry after the current one. A strobe while `valid_o` is clear has no effect.
- R7: In list mode, the entry after one marked end-of-sequence is entry 0. When the read position reaches the number of stored entries, the next entry is also entry 0.
- R8: `scan_end_o` is high for the one cycle after an edge at which a conversion strobe consumed a holding entry with bit 15 set. It is low otherwise.
- R9: With `int_mode_i` set, the holding register takes bits 13:8 from entry 0. Its channel starts at the channel of entry 0 and rises by one on each conversion. Bits 15 and 14 are both set when the channel is at or above `high_chan_i`. After such an entry, the channel returns to the channel of entry 0.
- R10: Without clear, prime or an accepted conversion, the holding register and `valid_o` keep their values. Pushes do not disturb them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_i | input | 1 | Clear list and read position |
| push_i | input | 1 | Append one entry |
| push_data_i | input | 16 | Entry to append |
| prime_i | input | 1 | Load entry 0 into the holding register |
| conv_i | input | 1 | Conversion strobe from the pacer |
| int_mode_i | input | 1 | Select channel-stepping mode |
| high_chan_i | input | 8 | Last channel in stepping mode |
| hold_o | output | 16 | Holding register |
| chan_o | output | 8 | Channel field of the holding register |
| gain_o | output | 2 | Gain field of the holding register |
| unip_o | output | 1 | Unipolar flag of the holding register |
| single_o | output | 1 | Single-ended flag of the holding register |
| valid_o | output | 1 | Holding register has been primed |
| scan_end_o | output | 1 | End-of-scan pulse to the pacer |
| overflow_o | output | 1 | Sticky dropped-push flag |

## Verification
The in-line assertions check the following on every cycle:
- the counting and overflow rules of the store: each accepted push adds one, a push to a full list sets the sticky flag, and a clear empties the list;
- the holding register stays put when no clear, prime or accepted conversion arrives;
- every `scan_end_o` pulse traces back to a consumed end-of-scan entry;
- an end-of-sequence entry sends the read position back to the start.

Some behaviours only the bench scenarios can show, against a behavioural model:
- the actual order of entries across several scans;
- the wrap when an unmarked list runs out;
- the field decode;
- channel stepping and its end condition in internal mode.

// File: rtl/adcq_pkg.sv
package adcq_pkg;

  typedef struct packed {
    logic       eoscan;  // bit 15
    logic       eoseq;   // bit 14
    logic       unip;    // bit 13
    logic       se;      // bit 12
    logic [1:0] rsvd;    // bits 11:10
    logic [1:0] gain;    // bits 9:8
    logic [7:0] chan;    // bits 7:0
  } adcq_entry_t;

  // Build a stepping-mode entry from the template and a channel.
  function automatic adcq_entry_t step_entry(input adcq_entry_t tmpl,
                                             input logic [7:0] ch,
                                             input logic [7:0] high);
    adcq_entry_t e;
    e        = tmpl;
    e.chan   = ch;
    e.eoscan = (ch >= high);
    e.eoseq  = (ch >= high);
    return e;
  endfunction

endpackage

// File: rtl/adcq_rst_sync.sv
module adcq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/adcq_store.sv
module adcq_store #(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [15:0]   push_data_i,
  input  logic [AW-1:0] rd_idx_i,
  output logic [15:0]   rd_data_o,
  output logic [15:0]   head_o,
  output logic [CW-1:0] count_o,
  output logic          overflow_o
);
  logic [CW-1:0] count_q, count_d;
  logic          ovf_q, ovf_d;
  logic          wr_en;
  logic          full;
  logic [15:0]   mem_q [DEPTH];

  assign full = (count_q == CW'(DEPTH));

  always_comb begin
    count_d = count_q;
    ovf_d   = ovf_q;
    wr_en   = 1'b0;
    if (clr_i) begin
      count_d = '0;
      ovf_d   = 1'b0;
    end else if (push_i) begin
      if (full) begin
        ovf_d = 1'b1;
      end else begin
        wr_en   = 1'b1;
        count_d = count_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      ovf_q   <= ovf_d;
    end
  end

  // One enable per slot; the write index is the current fill level.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (count_q == CW'(g))) mem_q[g] <= push_data_i;
    end
  end

  assign rd_data_o  = mem_q[rd_idx_i];
  assign head_o     = mem_q[0];
  assign count_o    = count_q;
  assign overflow_o = ovf_q;

  AST_APPEND_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !clr_i && !full) |=> (count_q == $past(count_q) + CW'(1))); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !clr_i && full) |=> (ovf_q && count_q == CW'(DEPTH))); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr_i) |=> ovf_q); // R4
  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (count_q == '0 && !ovf_q)); // R2
endmodule

// File: rtl/adcq_hold.sv
module adcq_hold
  import adcq_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          prime_i,
  input  logic          conv_i,
  input  logic          int_mode_i,
  input  logic [7:0]    high_chan_i,
  input  logic [CW-1:0] count_i,
  input  logic [15:0]   rd_data_i,
  input  logic [15:0]   head_i,
  output logic [AW-1:0] rd_idx_o,
  output logic [15:0]   hold_o,
  output logic          valid_o,
  output logic          scan_end_o
);
  adcq_entry_t   hold_q, hold_d;
  adcq_entry_t   head_e;
  logic          valid_q, valid_d;
  logic [CW-1:0] rptr_q, rptr_d;
  logic          se_q, se_d;
  logic [AW-1:0] ext_idx;
  logic [7:0]    step_chan;
  logic          take_conv;

  assign head_e    = adcq_entry_t'(head_i);
  assign take_conv = conv_i && valid_q && !prime_i && !clr_i;
  assign ext_idx   = (hold_q.eoseq || (rptr_q >= count_i)) ? '0 : rptr_q[AW-1:0];
  assign step_chan = hold_q.eoscan ? head_e.chan : (hold_q.chan + 8'd1);
  assign rd_idx_o  = prime_i ? '0 : ext_idx;

  always_comb begin
    hold_d  = hold_q;
    valid_d = valid_q;
    rptr_d  = rptr_q;
    se_d    = 1'b0;
    if (clr_i) begin
      hold_d  = '0;
      valid_d = 1'b0;
      rptr_d  = '0;
    end else if (prime_i) begin
      if (count_i != '0) begin
        valid_d = 1'b1;
        rptr_d  = CW'(1);
        hold_d  = int_mode_i ? step_entry(head_e, head_e.chan, high_chan_i)
                             : adcq_entry_t'(rd_data_i);
      end
    end else if (take_conv) begin
      se_d = hold_q.eoscan;
      if (int_mode_i) begin
        hold_d = step_entry(head_e, step_chan, high_chan_i);
      end else begin
        hold_d = adcq_entry_t'(rd_data_i);
        rptr_d = CW'(ext_idx) + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      valid_q <= 1'b0;
      rptr_q  <= '0;
      se_q    <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      valid_q <= valid_d;
      rptr_q  <= rptr_d;
      se_q    <= se_d;
    end
  end

  assign hold_o     = hold_q;
  assign valid_o    = valid_q;
  assign scan_end_o = se_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !prime_i && !conv_i) |=> ($stable(hold_q) && $stable(valid_q))); // R10
  AST_SCAN_END_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    se_q |-> $past(conv_i && valid_q && !clr_i && !prime_i && hold_q.eoscan)); // R8
  AST_SEQ_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (take_conv && !int_mode_i && hold_q.eoseq) |=> (rptr_q == CW'(1))); // R7
  AST_PRIME_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (prime_i && !clr_i && count_i == '0 && !valid_q) |=> !valid_q); // R5
  AST_CLR_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!valid_q && !se_q)); // R2
endmodule

// File: rtl/adc_chan_queue_seq.sv
module adc_chan_queue_seq
  import adcq_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_i,
  input  logic        push_i,
  input  logic [15:0] push_data_i,
  input  logic        prime_i,
  input  logic        conv_i,
  input  logic        int_mode_i,
  input  logic [7:0]  high_chan_i,
  output logic [15:0] hold_o,
  output logic [7:0]  chan_o,
  output logic [1:0]  gain_o,
  output logic        unip_o,
  output logic        single_o,
  output logic        valid_o,
  output logic        scan_end_o,
  output logic        overflow_o
);
  logic          rst_sync_n;
  logic [AW-1:0] rd_idx;
  logic [15:0]   rd_data;
  logic [15:0]   head;
  logic [CW-1:0] count;
  adcq_entry_t   hold_e;

  adcq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  adcq_store #(.DEPTH(DEPTH)) u_store (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .clr_i       (clr_i),
    .push_i      (push_i),
    .push_data_i (push_data_i),
    .rd_idx_i    (rd_idx),
    .rd_data_o   (rd_data),
    .head_o      (head),
    .count_o     (count),
    .overflow_o  (overflow_o)
  );

  adcq_hold #(.DEPTH(DEPTH)) u_hold (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .clr_i       (clr_i),
    .prime_i     (prime_i),
    .conv_i      (conv_i),
    .int_mode_i  (int_mode_i),
    .high_chan_i (high_chan_i),
    .count_i     (count),
    .rd_data_i   (rd_data),
    .head_i      (head),
    .rd_idx_o    (rd_idx),
    .hold_o      (hold_o),
    .valid_o     (valid_o),
    .scan_end_o  (scan_end_o)
  );

  assign hold_e   = adcq_entry_t'(hold_o);
  assign chan_o   = hold_e.chan;
  assign gain_o   = hold_e.gain;
  assign unip_o   = hold_e.unip;
  assign single_o = hold_e.se;
endmodule

// File: tb/adc_chan_queue_seq_bench.sv
`timescale 1ns/1ps
module adc_chan_queue_seq_bench;
  localparam int D = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        clr_i, push_i, prime_i, conv_i, int_mode_i;
  logic [15:0] push_data_i;
  logic [7:0]  high_chan_i;
  logic [15:0] hold_o;
  logic [7:0]  chan_o;
  logic [1:0]  gain_o;
  logic        unip_o, single_o, valid_o, scan_end_o, overflow_o;

  int n_cmp = 0;
  int n_bad = 0;

  // behavioural model state
  int mem[D];
  int cnt, rp, hold_m;
  bit vld_m, se_m, ovf_m;

  always #2 clk = ~clk;

  adc_chan_queue_seq u_adc_chan_queue_seq (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .push_i(push_i),
    .push_data_i(push_data_i), .prime_i(prime_i), .conv_i(conv_i),
    .int_mode_i(int_mode_i), .high_chan_i(high_chan_i), .hold_o(hold_o),
    .chan_o(chan_o), .gain_o(gain_o), .unip_o(unip_o), .single_o(single_o),
    .valid_o(valid_o), .scan_end_o(scan_end_o), .overflow_o(overflow_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=0x%0h expected=0x%0h", req, $time, act, exp);
    end
  endtask

  function automatic int ient(input int t, input int ch);
    int f;
    f = (ch >= int'(high_chan_i)) ? 1 : 0;
    return (f << 15) | (f << 14) | (t & 16'h3f00) | (ch & 255);
  endfunction

  task automatic compare_all();
    check("R1/R6 hold_o", int'(hold_o), hold_m);
    check("R1 chan_o", int'(chan_o), hold_m & 255);
    check("R1 gain_o", int'(gain_o), (hold_m >> 8) & 3);
    check("R1 single_o", int'(single_o), (hold_m >> 12) & 1);
    check("R1 unip_o", int'(unip_o), (hold_m >> 13) & 1);
    check("R5 valid_o", int'(valid_o), int'(vld_m));
    check("R8 scan_end_o", int'(scan_end_o), int'(se_m));
    check("R4 overflow_o", int'(overflow_o), int'(ovf_m));
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input bit c_clr, input bit c_push, input int d,
                     input bit c_prime, input bit c_conv);
    int idx, nch;
    clr_i = c_clr; push_i = c_push; push_data_i = d[15:0];
    prime_i = c_prime; conv_i = c_conv;
    @(posedge clk);
    se_m = 0;
    if (c_clr) begin
      cnt = 0; rp = 0; vld_m = 0; hold_m = 0; ovf_m = 0;
    end else begin
      if (c_prime) begin
        if (cnt > 0) begin
          vld_m = 1; rp = 1;
          hold_m = int_mode_i ? ient(mem[0], mem[0] & 255) : mem[0];
        end
      end else if (c_conv && vld_m) begin
        se_m = hold_m[15];
        if (int_mode_i) begin
          nch = hold_m[15] ? (mem[0] & 255) : ((hold_m & 255) + 1);
          hold_m = ient(mem[0], nch);
        end else begin
          idx = (hold_m[14] || rp >= cnt) ? 0 : rp;
          hold_m = mem[idx];
          rp = idx + 1;
        end
      end
      if (c_push) begin
        if (cnt < D) begin mem[cnt] = d & 16'hffff; cnt++; end
        else ovf_m = 1;
      end
    end
    @(negedge clk);
    compare_all();
    clr_i = 0; push_i = 0; prime_i = 0; conv_i = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic conv_run(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      cyc(0, 0, 0, 0, 1);
      idle(gap);
    end
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; clr_i = 0; push_i = 0; push_data_i = 0; prime_i = 0;
    conv_i = 0; int_mode_i = 0; high_chan_i = 0;
    cnt = 0; rp = 0; hold_m = 0; vld_m = 0; se_m = 0; ovf_m = 0;
    // reset state (R2 values)
    repeat (3) @(negedge clk);
    compare_all();
    rst_n = 1;
    idle(4);

    // R5: prime on empty list is ignored; R6: conversion without prime ignored
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 1);

    // R1 R3 R7 R8: four-entry list, last entry carries both end markers
    cyc(0, 1, 16'h1105, 0, 0);           // se, gain 1, ch 5
    cyc(0, 1, 16'h2206, 0, 0);           // unip, gain 2, ch 6
    cyc(0, 1, 16'h0307, 0, 0);           // differential, gain 3, ch 7
    cyc(0, 1, 16'hF00A, 0, 0);           // end of scan + sequence, ch 10
    cyc(0, 0, 0, 1, 0);
    conv_run(10, 0);                     // back-to-back strobes wrap twice
    conv_run(6, 2);                      // spaced strobes, R10 in the gaps

    // R5: prime has precedence over a same-cycle conversion
    cyc(0, 0, 0, 1, 1);
    conv_run(2, 0);

    // R2: clear with a push in the same cycle; push ignored
    cyc(1, 1, 16'h00FF, 0, 0);
    cyc(0, 0, 0, 1, 0);                  // still empty -> no prime
    // R8: end of scan mid-list, end of sequence at the end (two scans)
    cyc(0, 1, 16'h1001, 0, 0);
    cyc(0, 1, 16'h9002, 0, 0);
    cyc(0, 1, 16'h1003, 0, 0);
    cyc(0, 1, 16'hD004, 0, 0);
    cyc(0, 0, 0, 1, 0);
    conv_run(9, 1);
    // R10: pushes while running do not disturb the holding register
    cyc(0, 1, 16'h0020, 0, 0);
    cyc(0, 1, 16'h0021, 0, 1);

    // R4 R7: fill without end markers, overflow, wrap at fill level
    cyc(1, 0, 0, 0, 0);
    for (int i = 0; i < D; i++) cyc(0, 1, 16'h0240 + i, 0, 0);
    cyc(0, 1, 16'h0BAD, 0, 0);
    cyc(0, 1, 16'h0BAE, 0, 0);
    cyc(0, 0, 0, 1, 0);
    conv_run(D + 3, 0);
    idle(2);                             // overflow stays set

    // R7: short list with no end marker wraps at its length
    cyc(1, 0, 0, 0, 0);
    cyc(0, 1, 16'h0011, 0, 0);
    cyc(0, 1, 16'h0012, 0, 0);
    cyc(0, 0, 0, 1, 0);
    conv_run(5, 0);

    // R9: internal stepping from ch 3 to ch 6 with template settings
    cyc(1, 0, 0, 0, 0);
    int_mode_i = 1; high_chan_i = 8'd6;
    cyc(0, 1, 16'h3203, 0, 0);
    cyc(0, 0, 0, 1, 0);
    conv_run(9, 0);
    // R9: start channel above the high channel ends every scan
    cyc(1, 0, 0, 0, 0);
    high_chan_i = 8'd2;
    cyc(0, 1, 16'h1109, 0, 0);
    cyc(0, 0, 0, 1, 0);
    conv_run(3, 1);
    int_mode_i = 0;
    idle(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule